// File: doc/BRIEF.md
# Pipelined Decision Tree Classifier

The block labels one connection record as normal traffic or as an attack. A record is six unsigned 32-bit statistics presented together on one input bus: how long the connection lasted, its transport protocol, the bytes sent in each direction, and two short-window connection counts. The labelling follows a fixed binary threshold tree that is three comparisons deep. Every internal node compares one chosen statistic against a constant. The tree shape, the constants and the leaf labels are set by parameters when the block is built.

The tree is split into a root decision stage and two subtree units, one for each side. When a record is accepted, the root compares its own statistic and wakes only one subtree unit. That unit walks its two remaining levels and holds a one-bit verdict together with a valid flag. An output register takes the verdict from whichever unit holds one and presents it downstream. Both the upstream and the downstream edge use valid/ready handshakes. Each subtree unit also has its own enable, valid and ready signals towards the root and the output register.

Top module: `dtree_classifier`

## Requirements
- R1: After reset, m_valid is 0 and s_ready is 1.
- R2: The feature bus s_feat holds feature i in bits [32*i+31 : 32*i]. The order is: 0 duration, 1 protocol (0 tcp, 1 udp, 2 icmp), 2 source bytes, 3 destination bytes, 4 same-host count, 5 same-service count. Each node steps left when its feature is less than or equal to its threshold, and right otherwise.
- R3: Each accepted sample enables exactly one subtree, chosen by the root comparison. The other subtree stays idle.
- R4: m_pred is the leaf label reached (1 = attack). Inside a subtree, the leaf index is {first node went right, second node went right}. The second node is the left child when the first node went left, and the right child when it went right. A label vector's bit n is leaf n.
- R5: s_ready is 0 while either subtree holds a result that the output register has not yet taken.
- R6: While m_valid is 1 and m_ready is 0, m_valid and m_pred stay unchanged.
- R7: Every accepted sample yields exactly one result, in arrival order.
- R8: If a sample is accepted on clock edge k while m_valid is 0, then m_valid is 0 before edge k+1 and 1 after edge k+1.
- R9: A feature equal to a node's threshold takes the left branch. The same feature at threshold plus one takes the right branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Upstream sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_feat | input | 192 | Six packed 32-bit features |
| m_valid | output | 1 | Verdict valid |
| m_ready | input | 1 | Downstream accepts the verdict |
| m_pred | output | 1 | Verdict, 1 = attack |

## Verification
Two events can share one clock edge: the output register hands its held verdict downstream, and on the same edge it reloads from a subtree whose result was waiting. The bench causes this by sending samples back to back while m_ready follows a random pattern, so a stalled verdict is often released exactly when the next subtree result is ready. The scoreboard then checks that no verdict is lost, repeated or reordered. A second check confirms that the released verdict was held unchanged for as long as m_ready stayed low.

// File: rtl/dtree_branch.sv
module dtree_branch #(
  parameter int unsigned W  = 32,
  parameter int unsigned NF = 6,
  parameter int unsigned FA = 0,
  parameter logic [W-1:0] TA = '0,
  parameter int unsigned FB = 0,
  parameter logic [W-1:0] TB = '0,
  parameter int unsigned FC = 0,
  parameter logic [W-1:0] TC = '0,
  parameter logic [3:0] LEAF = 4'b0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NF*W-1:0] feat,
  input  logic          take,
  output logic          ready,
  output logic          valid,
  output logic          pred
);
  logic a_r, b_r, c_r;
  logic [1:0] idx;
  logic unused_bits;

  assign a_r = feat[FA*W +: W] > TA;
  assign b_r = feat[FB*W +: W] > TB;
  assign c_r = feat[FC*W +: W] > TC;
  assign idx = {a_r, a_r ? c_r : b_r};
  assign ready = !valid;
  assign unused_bits = ^feat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      pred  <= 1'b0;
    end else if (en && !valid) begin
      valid <= 1'b1;
      pred  <= LEAF[idx];
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dtree_classifier.sv
module dtree_classifier #(
  parameter int unsigned W  = 32,
  parameter int unsigned NF = 6,
  parameter int unsigned ROOT_F = 2,
  parameter logic [W-1:0] ROOT_T = 32'd1000,
  parameter int unsigned L_FA = 4,
  parameter logic [W-1:0] L_TA = 32'd50,
  parameter int unsigned L_FB = 1,
  parameter logic [W-1:0] L_TB = 32'd0,
  parameter int unsigned L_FC = 0,
  parameter logic [W-1:0] L_TC = 32'd10,
  parameter logic [3:0] L_LEAF = 4'b1010,
  parameter int unsigned R_FA = 3,
  parameter logic [W-1:0] R_TA = 32'd500,
  parameter int unsigned R_FB = 5,
  parameter logic [W-1:0] R_TB = 32'd20,
  parameter int unsigned R_FC = 4,
  parameter logic [W-1:0] R_TC = 32'd100,
  parameter logic [3:0] R_LEAF = 4'b1101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [NF*W-1:0] s_feat,
  output logic            m_valid,
  input  logic            m_ready,
  output logic            m_pred
);
  logic go_r, acc, out_free;
  logic en_l, en_r, rdy_l, rdy_r, lv, rv, lp, rp, take_l, take_r;

  assign s_ready  = rdy_l & rdy_r;
  assign acc      = s_valid & s_ready;
  assign go_r     = s_feat[ROOT_F*W +: W] > ROOT_T;
  assign en_l     = acc & !go_r;
  assign en_r     = acc & go_r;
  assign out_free = !m_valid | m_ready;
  assign take_l   = lv & out_free;
  assign take_r   = rv & out_free;

  dtree_branch #(.W(W), .NF(NF), .FA(L_FA), .TA(L_TA), .FB(L_FB), .TB(L_TB),
                 .FC(L_FC), .TC(L_TC), .LEAF(L_LEAF)) left_i (
    .clk(clk), .rst_n(rst_n), .en(en_l), .feat(s_feat), .take(take_l),
    .ready(rdy_l), .valid(lv), .pred(lp));

  dtree_branch #(.W(W), .NF(NF), .FA(R_FA), .TA(R_TA), .FB(R_FB), .TB(R_TB),
                 .FC(R_FC), .TC(R_TC), .LEAF(R_LEAF)) right_i (
    .clk(clk), .rst_n(rst_n), .en(en_r), .feat(s_feat), .take(take_r),
    .ready(rdy_r), .valid(rv), .pred(rp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_pred  <= 1'b0;
    end else if ((lv | rv) && out_free) begin
      m_valid <= 1'b1;
      m_pred  <= lv ? lp : rp;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dtree_classifier_chk.sv
module dtree_classifier_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic m_valid,
  input logic m_ready,
  input logic m_pred,
  input logic en_l,
  input logic en_r,
  input logic lv,
  input logic rv
);
  p_one_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_l, en_r}));
  p_accept_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (en_l || en_r));
  p_left_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_l |=> (lv && !rv));
  p_right_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_r |=> (rv && !lv));
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lv || rv) |-> !s_ready);
  p_single_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lv && rv));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pred)));
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !m_valid) |=> (!m_valid ##1 m_valid));
endmodule

bind dtree_classifier dtree_classifier_chk chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_pred(m_pred),
  .en_l(en_l), .en_r(en_r), .lv(lv), .rv(rv));

// File: tb/dtree_classifier_tb_top.sv
module dtree_classifier_tb_top;
  localparam int W = 32;
  localparam int NF = 6;
  localparam logic [3:0] LL = 4'b1010;
  localparam logic [3:0] RL = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [NF*W-1:0] s_feat = '0;
  logic m_ready = 1'b1;
  logic s_ready, m_valid, m_pred;

  int checks = 0;
  int fails = 0;
  int sent = 0;
  int got = 0;
  int mode = 0;
  bit exp_q[$];
  bit prev_hold = 1'b0;
  bit prev_pred = 1'b0;

  always #4 clk = ~clk;

  dtree_classifier #(
    .W(W), .NF(NF), .ROOT_F(2), .ROOT_T(32'd1000),
    .L_FA(4), .L_TA(32'd50), .L_FB(1), .L_TB(32'd0), .L_FC(0), .L_TC(32'd10), .L_LEAF(LL),
    .R_FA(3), .R_TA(32'd500), .R_FB(5), .R_TB(32'd20), .R_FC(4), .R_TC(32'd100), .R_LEAF(RL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_feat(s_feat),
    .m_valid(m_valid), .m_ready(m_ready), .m_pred(m_pred));

  function automatic logic [NF*W-1:0] pack(int unsigned d, int unsigned p, int unsigned sb,
                                           int unsigned db, int unsigned c, int unsigned sc);
    return {sc[31:0], c[31:0], db[31:0], sb[31:0], p[31:0], d[31:0]};
  endfunction

  function automatic bit predict(logic [NF*W-1:0] f);
    logic [W-1:0] v [NF];
    bit a, s;
    for (int i = 0; i < NF; i++) v[i] = f[i*W +: W];
    if (v[2] <= 1000) begin
      a = v[4] > 50;
      s = a ? (v[0] > 10) : (v[1] > 0);
      return LL[{a, s}];
    end
    a = v[3] > 500;
    s = a ? (v[4] > 100) : (v[5] > 20);
    return RL[{a, s}];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [NF*W-1:0] f);
    @(negedge clk);
    s_valid = 1'b1;
    s_feat = f;
    forever begin
      #3;
      if (s_ready) begin
        exp_q.push_back(predict(f));
        sent++;
        @(posedge clk);
        #1;
        break;
      end
      @(negedge clk);
    end
    s_valid = 1'b0;
    @(negedge clk);
    #3;
    check(s_ready == 1'b0, "R5 s_ready while result held", int'(s_ready), 0);
  endtask

  always @(negedge clk) begin
    if (mode == 0) m_ready <= 1'b1;
    else if (mode == 1) m_ready <= ($urandom_range(0, 1) == 1);
    else m_ready <= ($urandom_range(0, 7) == 0);
  end

  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (prev_hold)
        check(m_valid && (m_pred == prev_pred), "R6 held output", int'({m_valid, m_pred}),
              int'({1'b1, prev_pred}));
      prev_hold = m_valid && !m_ready;
      prev_pred = m_pred;
      if (m_valid && m_ready) begin
        got++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", got, sent);
        end else begin
          bit e;
          e = exp_q.pop_front();
          check(m_pred == e, "R4 R2 R3 R7 verdict", int'(m_pred), int'(e));
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || m_valid) && n < 1000) begin
      @(posedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check(m_valid == 1'b0, "R1 m_valid in reset", int'(m_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    check(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
    check(s_ready == 1'b1, "R1 s_ready after reset", int'(s_ready), 1);

    mode = 0;
    @(negedge clk);
    // R8 latency: accept, then m_valid low one sample later, high after next edge
    send(pack(5, 0, 100, 10, 10, 1));
    check(m_valid == 1'b0, "R8 m_valid one edge after accept", int'(m_valid), 0);
    @(negedge clk);
    #3;
    check(m_valid == 1'b1, "R8 m_valid two edges after accept", int'(m_valid), 1);
    drain();

    // R9 and R2 boundaries, R3 side selection
    send(pack(0, 0, 1000, 0, 0, 0));
    send(pack(0, 0, 1001, 0, 0, 0));
    send(pack(0, 0, 1000, 0, 50, 0));
    send(pack(0, 0, 1000, 0, 51, 0));
    send(pack(10, 0, 0, 0, 60, 0));
    send(pack(11, 0, 0, 0, 60, 0));
    send(pack(0, 1, 0, 0, 0, 0));
    send(pack(0, 2, 0, 0, 0, 0));
    send(pack(0, 0, 2000, 500, 0, 20));
    send(pack(0, 0, 2000, 500, 0, 21));
    send(pack(0, 0, 2000, 501, 100, 0));
    send(pack(0, 0, 2000, 501, 101, 0));
    send(pack(0, 0, 2000, 501, 0, 40));
    drain();

    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int i = 0; i < 150; i++)
        send(pack($urandom_range(0, 20), $urandom_range(0, 2), $urandom_range(0, 2000),
                  $urandom_range(0, 1000), $urandom_range(0, 200), $urandom_range(0, 40)));
      mode = 0;
      drain();
    end

    check(got == sent && exp_q.size() == 0, "R7 result count", got, sent);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule